// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the 8-bit arithmetic and logic unit of a small processor built around an accumulator. Each cycle it takes the accumulator value, a second 8-bit operand, the current flag byte and a 4-bit operation code. It returns the result, the new flag byte and a strobe that says whether the result is written back. The operations are the eight two-operand operations, an increment and a decrement of the operand, and three single-operand operations: complement the accumulator, force the carry flag, and toggle the carry flag.

The computation itself is combinational. A thin registered stage holds the result, the flags and the write strobe for one clock, so they appear on the outputs one cycle after the inputs are sampled.

The flag byte puts zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. Bits 3:0 are always driven low.

Top module: `accum_alu`

## Requirements
- R1: Operation codes: 0 ADD, 1 ADD with carry, 2 SUB, 3 SUB with carry, 4 AND, 5 XOR, 6 OR, 7 COMPARE, 8 increment operand, 9 decrement operand, 10 complement accumulator, 11 set carry, 12 complement carry. Codes 13 to 15 return the accumulator, keep flag bits 7:4 and do not write. Outputs show the result of the inputs sampled at the previous rising clock edge.
- R2: Flag byte layout: Z is bit 7, N is bit 6, H is bit 5 and C is bit 4. Bits 3:0 of the output flags are always 0, whatever the incoming flags hold.
- R3: ADD and ADD with carry clear N. H is set when the two low nibbles plus the carry-in exceed 15. C is set when the full sum exceeds 255. The carry-in is the incoming C for ADD with carry and 0 for ADD.
- R4: SUB, SUB with carry and COMPARE set N. H is set when the operand's low nibble plus the carry-in is greater than the accumulator's low nibble. C is set when the operand plus the carry-in is greater than the accumulator. The result is A minus operand minus carry-in, modulo 256.
- R5: AND sets H and clears N and C. XOR and OR clear N, H and C. The result is the bitwise function of the accumulator and the operand.
- R6: COMPARE returns the same flags as SUB and holds the write strobe low. Set carry, complement carry and codes 13 to 15 also hold it low. All other codes raise it.
- R7: For codes 0 to 9, Z is 1 exactly when the 8-bit result is zero.
- R8: Increment returns the operand plus 1, clears N, and sets H when the result's low nibble is 0. Decrement returns the operand minus 1, sets N, and sets H when the result's low nibble is 15. Both keep the incoming C.
- R9: Complement returns the inverted accumulator and sets N and H. Set carry makes C 1. Complement carry inverts C. Both carry operations clear N and H and return the accumulator unchanged. All three keep the incoming Z. Complement also keeps the incoming C.
- R10: While reset is active, and at the first sample after it, the result, the flags and the write strobe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge samples the inputs |
| rstN | input | 1 | Active-low synchronous reset |
| opCode | input | 4 | Operation select (see R1) |
| accIn | input | 8 | Accumulator value |
| opndIn | input | 8 | Second operand, and the source for increment and decrement |
| flagsIn | input | 8 | Current flag byte |
| resultOut | output | 8 | Registered result |
| flagsOut | output | 8 | Registered new flag byte |
| writeOut | output | 1 | Registered result write strobe |

## Verification
Directed vectors cover the nibble and byte boundaries: 0x0F+0x01, 0xFF+0x01 and 0x0F+0x00 with carry-in. These show a half-carry on its own, a full carry with a zero result, and a carry that comes only from the incoming C. Subtractions of equal values, with and without carry-in, show the borrow-by-one case apart from a clean zero. Increments across 0x0F and 0xFF, and decrements across 0x10 and 0x00, show that H follows the result nibble while C is kept. Seeded random vectors over all sixteen codes, with random incoming flags, make sure no flag leaks through from the input or from another operation.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  localparam int DATA_W   = 8;
  localparam int NIB_W    = 4;
  localparam int OP_W     = 4;
  localparam int FLAG_Z   = 7;
  localparam int FLAG_N   = 6;
  localparam int FLAG_H   = 5;
  localparam int FLAG_C   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_CMP  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_CPL  = 4'd10,
    OP_SCF  = 4'd11,
    OP_CCF  = 4'd12
  } aluOp_e;

  // Strobes from control to datapath; at most one unit strobe is high.
  typedef struct packed {
    logic addEn;
    logic subEn;
    logic andEn;
    logic xorEn;
    logic orEn;
    logic incEn;
    logic decEn;
    logic cplEn;
    logic scfEn;
    logic ccfEn;
    logic useCarry;
    logic writeEn;
  } aluStrobe_t;

endpackage

// File: rtl/accum_alu_ctrl.sv
module accum_alu_ctrl
  import accum_alu_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluStrobe_t      strobe
);

  always_comb begin
    strobe = '0;
    case (opCode)
      OP_ADD:  begin strobe.addEn = 1'b1; strobe.writeEn = 1'b1; end
      OP_ADC:  begin strobe.addEn = 1'b1; strobe.useCarry = 1'b1; strobe.writeEn = 1'b1; end
      OP_SUB:  begin strobe.subEn = 1'b1; strobe.writeEn = 1'b1; end
      OP_SBC:  begin strobe.subEn = 1'b1; strobe.useCarry = 1'b1; strobe.writeEn = 1'b1; end
      OP_AND:  begin strobe.andEn = 1'b1; strobe.writeEn = 1'b1; end
      OP_XOR:  begin strobe.xorEn = 1'b1; strobe.writeEn = 1'b1; end
      OP_OR:   begin strobe.orEn  = 1'b1; strobe.writeEn = 1'b1; end
      OP_CMP:  begin strobe.subEn = 1'b1; end
      OP_INC:  begin strobe.incEn = 1'b1; strobe.writeEn = 1'b1; end
      OP_DEC:  begin strobe.decEn = 1'b1; strobe.writeEn = 1'b1; end
      OP_CPL:  begin strobe.cplEn = 1'b1; strobe.writeEn = 1'b1; end
      OP_SCF:  begin strobe.scfEn = 1'b1; end
      OP_CCF:  begin strobe.ccfEn = 1'b1; end
      default: strobe = '0;
    endcase
  end

  always_comb begin
    assert ($onehot0({strobe.addEn, strobe.subEn, strobe.andEn, strobe.xorEn,
                      strobe.orEn, strobe.incEn, strobe.decEn, strobe.cplEn,
                      strobe.scfEn, strobe.ccfEn}));  // R1
    assert (!(strobe.writeEn && (strobe.scfEn || strobe.ccfEn)));  // R6
  end

endmodule

// File: rtl/accum_alu_dp.sv
module accum_alu_dp
  import accum_alu_pkg::*;
(
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] opndIn,
  input  logic [3:0]        flagsHiIn,
  input  aluStrobe_t        strobe,
  output logic [DATA_W-1:0] resultOut,
  output logic [DATA_W-1:0] flagsOut
);

  localparam int HI_BASE = FLAG_C;

  logic              carryIn;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W:0]   diffWide;
  logic              halfCarry;
  logic              halfBorrow;
  logic [DATA_W-1:0] incVal;
  logic [DATA_W-1:0] decVal;
  logic              zIn;
  logic              nIn;
  logic              hIn;
  logic              cIn;
  logic              zOut;
  logic              nOut;
  logic              hOut;
  logic              cOut;
  logic              zFromResult;

  assign zIn = flagsHiIn[FLAG_Z-HI_BASE];
  assign nIn = flagsHiIn[FLAG_N-HI_BASE];
  assign hIn = flagsHiIn[FLAG_H-HI_BASE];
  assign cIn = flagsHiIn[FLAG_C-HI_BASE];

  assign carryIn = strobe.useCarry & cIn;

  always_comb begin
    sumWide    = {1'b0, accIn} + {1'b0, opndIn} + {{DATA_W{1'b0}}, carryIn};
    diffWide   = {1'b0, accIn} - {1'b0, opndIn} - {{DATA_W{1'b0}}, carryIn};
    halfCarry  = ({1'b0, accIn[NIB_W-1:0]} + {1'b0, opndIn[NIB_W-1:0]}
                  + {{NIB_W{1'b0}}, carryIn}) > (NIB_W+1)'((1 << NIB_W) - 1);
    halfBorrow = ({1'b0, opndIn[NIB_W-1:0]} + {{NIB_W{1'b0}}, carryIn})
                  > {1'b0, accIn[NIB_W-1:0]};
    incVal     = opndIn + DATA_W'(1);
    decVal     = opndIn - DATA_W'(1);
  end

  always_comb begin
    resultOut   = accIn;
    zFromResult = 1'b0;
    nOut        = nIn;
    hOut        = hIn;
    cOut        = cIn;
    if (strobe.addEn) begin
      resultOut   = sumWide[DATA_W-1:0];
      zFromResult = 1'b1;
      nOut        = 1'b0;
      hOut        = halfCarry;
      cOut        = sumWide[DATA_W];
    end else if (strobe.subEn) begin
      resultOut   = diffWide[DATA_W-1:0];
      zFromResult = 1'b1;
      nOut        = 1'b1;
      hOut        = halfBorrow;
      cOut        = diffWide[DATA_W];
    end else if (strobe.andEn || strobe.xorEn || strobe.orEn) begin
      resultOut   = strobe.andEn ? (accIn & opndIn) :
                    strobe.xorEn ? (accIn ^ opndIn) : (accIn | opndIn);
      zFromResult = 1'b1;
      nOut        = 1'b0;
      hOut        = strobe.andEn;
      cOut        = 1'b0;
    end else if (strobe.incEn || strobe.decEn) begin
      resultOut   = strobe.incEn ? incVal : decVal;
      zFromResult = 1'b1;
      nOut        = strobe.decEn;
      hOut        = strobe.incEn ? (incVal[NIB_W-1:0] == '0)
                                 : (decVal[NIB_W-1:0] == '1);
      cOut        = cIn;
    end else if (strobe.cplEn) begin
      resultOut   = ~accIn;
      nOut        = 1'b1;
      hOut        = 1'b1;
    end else if (strobe.scfEn || strobe.ccfEn) begin
      nOut        = 1'b0;
      hOut        = 1'b0;
      cOut        = strobe.scfEn ? 1'b1 : ~cIn;
    end
    zOut = zFromResult ? (resultOut == '0) : zIn;
  end

  always_comb begin
    flagsOut               = '0;
    flagsOut[FLAG_Z]       = zOut;
    flagsOut[FLAG_N]       = nOut;
    flagsOut[FLAG_H]       = hOut;
    flagsOut[FLAG_C]       = cOut;
  end

  always_comb begin
    assert (!(strobe.incEn || strobe.decEn) || (cOut == cIn));  // R8
    assert (!strobe.cplEn || (resultOut ^ accIn) == '1);         // R9
  end

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] opndIn,
  input  logic [DATA_W-1:0] flagsIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [DATA_W-1:0] flagsOut,
  output logic              writeOut
);

  aluStrobe_t        strobe;
  logic [DATA_W-1:0] resultNext;
  logic [DATA_W-1:0] flagsNext;
  logic [OP_W-1:0]   opQ;
  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] flagsInQ;

  accum_alu_ctrl uCtrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  accum_alu_dp uDp (
    .accIn     (accIn),
    .opndIn    (opndIn),
    .flagsHiIn (flagsIn[DATA_W-1:FLAG_C]),
    .strobe    (strobe),
    .resultOut (resultNext),
    .flagsOut  (flagsNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultOut <= '0;
      flagsOut  <= '0;
      writeOut  <= 1'b0;
      opQ       <= '1;
      accQ      <= '0;
      flagsInQ  <= '0;
    end else begin
      resultOut <= resultNext;
      flagsOut  <= flagsNext;
      writeOut  <= strobe.writeEn;
      opQ       <= opCode;
      accQ      <= accIn;
      flagsInQ  <= flagsIn;
    end
  end

  AST_LOW_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (flagsInQ[3:0] != '0) |-> (flagsOut[3:0] == '0));  // R2
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opQ == OP_CMP) |-> !writeOut);  // R6
  AST_CARRY_OP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (opQ == OP_SCF || opQ == OP_CCF) |-> (resultOut == accQ && !writeOut
      && flagsOut[FLAG_Z] == flagsInQ[FLAG_Z]));  // R9
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (opQ <= OP_DEC) |-> (flagsOut[FLAG_Z] == (resultOut == '0)));  // R7
  AST_SUB_SETS_N: assert property (@(posedge clk) disable iff (!rstN)
    (opQ == OP_SUB || opQ == OP_SBC || opQ == OP_CMP) |-> flagsOut[FLAG_N]);  // R4
  AST_ADD_CLEARS_N: assert property (@(posedge clk) disable iff (!rstN)
    (opQ == OP_ADD || opQ == OP_ADC) |-> !flagsOut[FLAG_N]);  // R3
  AST_SPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opQ > OP_CCF) |-> (!writeOut && resultOut == accQ));  // R1
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(!rstN) |-> (resultOut == '0 && flagsOut == '0 && !writeOut));  // R10

endmodule

// File: tb/accum_alu_test.sv
module accum_alu_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] accIn = '0;
  logic [7:0] opndIn = '0;
  logic [7:0] flagsIn = '0;
  logic [7:0] resultOut;
  logic [7:0] flagsOut;
  logic       writeOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accum_alu uut (
    .clk       (clk),
    .rstN      (rstN),
    .opCode    (opCode),
    .accIn     (accIn),
    .opndIn    (opndIn),
    .flagsIn   (flagsIn),
    .resultOut (resultOut),
    .flagsOut  (flagsOut),
    .writeOut  (writeOut)
  );

  // Returns {write, flags, result} from the requirements.
  function automatic logic [16:0] refModel(input logic [3:0] op, input logic [7:0] a,
                                           input logic [7:0] b, input logic [7:0] f);
    int ai = int'(a);
    int bi = int'(b);
    int ci = (op == 4'd1 || op == 4'd3) ? int'(f[4]) : 0;
    int r = ai;
    bit z = f[7], n = f[6], h = f[5], c = f[4], w = 1'b0, zr = 1'b1;
    case (op)
      4'd0, 4'd1: begin
        r = (ai + bi + ci) % 256; n = 0;
        h = ((ai % 16) + (bi % 16) + ci) > 15; c = (ai + bi + ci) > 255; w = 1;
      end
      4'd2, 4'd3, 4'd7: begin
        r = (ai - bi - ci + 512) % 256; n = 1;
        h = ((bi % 16) + ci) > (ai % 16); c = (bi + ci) > ai; w = (op != 4'd7);
      end
      4'd4: begin r = int'(a & b); n = 0; h = 1; c = 0; w = 1; end
      4'd5: begin r = int'(a ^ b); n = 0; h = 0; c = 0; w = 1; end
      4'd6: begin r = int'(a | b); n = 0; h = 0; c = 0; w = 1; end
      4'd8: begin r = (bi + 1) % 256; n = 0; h = (r % 16) == 0; w = 1; end
      4'd9: begin r = (bi + 255) % 256; n = 1; h = (r % 16) == 15; w = 1; end
      4'd10: begin r = 255 - ai; n = 1; h = 1; w = 1; zr = 0; end
      4'd11: begin n = 0; h = 0; c = 1; zr = 0; end
      4'd12: begin n = 0; h = 0; c = !f[4]; zr = 0; end
      default: begin zr = 0; end
    endcase
    if (zr) z = (r == 0);
    return {w, z, n, h, c, 4'b0000, 8'(r)};
  endfunction

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd7: return "R6";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd8, 4'd9: return "R8";
      4'd10, 4'd11, 4'd12: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: op=%0d a=%02h b=%02h f=%02h got w=%0b f=%02h r=%02h exp w=%0b f=%02h r=%02h",
               tag, opCode, accIn, opndIn, flagsIn, got[16], got[15:8], got[7:0],
               exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  // Drive at falling edge, result registered at the next rising edge, sample at the following falling edge.
  task automatic apply(input string tag, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] f);
    opCode = op; accIn = a; opndIn = b; flagsIn = f;
    @(negedge clk);
    check(tag, {writeOut, flagsOut, resultOut}, refModel(op, a, b, f));
  endtask

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R10", {writeOut, flagsOut, resultOut}, 17'd0);
    rstN = 1'b1;
    opCode = 4'd0; accIn = 8'h05; opndIn = 8'h06;
    @(negedge clk);
    check("R10", {writeOut, flagsOut, resultOut}, refModel(4'd0, 8'h05, 8'h06, 8'h00));

    apply("R3", 4'd0, 8'h0F, 8'h01, 8'h00);    // half carry only
    apply("R7", 4'd0, 8'hFF, 8'h01, 8'h00);    // full carry, zero result
    apply("R3", 4'd1, 8'h0F, 8'h00, 8'h10);    // carry-in produces H
    apply("R3", 4'd1, 8'hFF, 8'h00, 8'h10);
    apply("R4", 4'd2, 8'h10, 8'h01, 8'h00);    // nibble borrow
    apply("R7", 4'd2, 8'h42, 8'h42, 8'h00);    // equal -> zero
    apply("R4", 4'd3, 8'h42, 8'h42, 8'h10);    // borrow by carry-in
    apply("R6", 4'd7, 8'h30, 8'h30, 8'h00);    // compare, no write
    apply("R6", 4'd7, 8'h01, 8'h80, 8'hF0);
    apply("R5", 4'd4, 8'hF0, 8'h0F, 8'hF0);    // AND zero with H
    apply("R5", 4'd5, 8'hAA, 8'hAA, 8'hF0);
    apply("R5", 4'd6, 8'h00, 8'h00, 8'hF0);
    apply("R8", 4'd8, 8'h00, 8'h0F, 8'h10);
    apply("R8", 4'd8, 8'h00, 8'hFF, 8'h00);
    apply("R8", 4'd9, 8'h00, 8'h10, 8'h10);
    apply("R8", 4'd9, 8'h00, 8'h00, 8'h00);
    apply("R9", 4'd10, 8'h5A, 8'h00, 8'h90);
    apply("R9", 4'd11, 8'h00, 8'h33, 8'h60);
    apply("R9", 4'd12, 8'h77, 8'h33, 8'hF0);
    apply("R9", 4'd12, 8'h77, 8'h33, 8'h80);
    apply("R1", 4'd13, 8'h12, 8'h34, 8'hA5);
    apply("R1", 4'd15, 8'h00, 8'hFF, 8'h5F);
    apply("R2", 4'd0, 8'h01, 8'h01, 8'h0F);    // low flag bits ignored

    for (int i = 0; i < 600; i++) begin
      logic [3:0] op = 4'($urandom);
      logic [7:0] a = 8'($urandom);
      logic [7:0] b = 8'($urandom);
      logic [7:0] f = 8'($urandom);
      apply((f[3:0] != 0 && i % 2 == 0) ? "R2" : tagOf(op), op, a, b, f);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: R1 run did not complete, got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule